// File: doc/BRIEF.md
# Register-Stage Bit-Flip Fault Injector

This block wraps the output of one register stage so that a verification or self-test environment can corrupt the stage for a single clock cycle. It takes the stage's data vector, a fault mask with one bit per storage bit, and an inject strobe. When the strobe is high and the mask is legal, the output is the data with every masked bit inverted. On every other cycle the data passes through untouched. The flip is applied at the point after the second latch of the stage. Corrupting there covers two cases: data that arrived at the stage already bad, and a stored node that was upset directly.

A mask is legal when it holds exactly `N_HOT` ones. A second condition comes from the pipeline. A data item that already took a fault in an earlier stage carries a taint bit, and it must not take a further, independent fault. So a strobe on a tainted item is refused, in the same way as a strobe with the wrong number of ones. A refused strobe changes nothing at the data output. It raises an error flag in that same cycle.

The taint bit travels beside the data to the next stage. A saturating counter records every flip that is applied. The counter can be cleared synchronously.

Top module: `fi_stage_injector`

## Requirements
- R1: While `inject_i` is low, `data_o` equals `data_i` bit for bit in the same cycle, whatever `fault_vec_i` holds.
- R2: When `inject_i` is high, `taint_i` is low and `fault_vec_i` has exactly `N_HOT` ones, `data_o` equals `data_i ^ fault_vec_i` in the same cycle. Bit i of the mask inverts bit i of the data, so the output differs from the input in exactly `N_HOT` positions.
- R3: A corruption lasts only for the cycle in which the strobe is high. In the next cycle with `inject_i` low, `data_o` equals `data_i` again.
- R4: When `inject_i` is high and the number of ones in `fault_vec_i` differs from `N_HOT` (zero ones included), `constraint_err_o` is high in that cycle, `data_o` equals `data_i`, and the counter does not advance.
- R5: `constraint_err_o` is low in every cycle where `inject_i` is low.
- R6: `taint_o` is high when `taint_i` is high or a flip is applied in that cycle. Otherwise it is low.
- R7: When `inject_i` is high and `taint_i` is high, the flip is refused: `constraint_err_o` is high, `data_o` equals `data_i`, and the counter does not advance.
- R8: Each applied flip adds one to `inject_cnt_o`, visible after the next rising clock edge.
- R9: The counter saturates at all ones. An applied flip at that value leaves it unchanged.
- R10: After reset `inject_cnt_o` is zero. `cnt_clr_i` high at a rising edge sets the counter to zero, and it takes priority over an increment in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_i | input | DATA_W | Stage data after the second latch |
| fault_vec_i | input | DATA_W | Mask of bits to invert, one per storage bit |
| inject_i | input | 1 | Apply the mask in this cycle |
| taint_i | input | 1 | Item already faulted upstream |
| cnt_clr_i | input | 1 | Synchronous clear of the injection counter |
| data_o | output | DATA_W | Stage output, possibly corrupted |
| taint_o | output | 1 | Taint forwarded with the item |
| constraint_err_o | output | 1 | Strobe refused: wrong popcount or tainted item |
| inject_cnt_o | output | CNT_W | Saturating count of applied flips |

## Verification
The data path holds no state, so a wrong decision in the popcount or legality logic shows at `data_o` and `constraint_err_o` in the same cycle as the strobe. A mask that is wrongly accepted changes `data_o`. A legal mask that is wrongly refused raises the flag. The only state is the counter. A missed, doubled or wrapping increment shows on `inject_cnt_o` one edge after the strobe. The bench therefore checks the counter against a model count after every scenario, and drives a narrow counter instance into saturation.

// File: rtl/fi_pkg.sv
package fi_pkg;
   typedef enum logic {
      POP_LOOP  = 1'b0,
      POP_CHUNK = 1'b1
   } pop_style_e;

   function automatic int unsigned pop_width(input int unsigned w);
      return $clog2(w + 1);
   endfunction
endpackage

// File: rtl/fi_popcount.sv
module fi_popcount
   import fi_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter pop_style_e  STYLE = POP_CHUNK,
   parameter int unsigned PW    = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [PW-1:0] cnt
);
   if (W < 1) begin : g_bad_w
      $error("fi_popcount: W must be at least 1");
   end
   if (PW < $clog2(W + 1)) begin : g_bad_pw
      $error("fi_popcount: PW too narrow for W");
   end

   if (STYLE == POP_LOOP) begin : g_loop
      always_comb begin
         cnt = '0;
         for (int i = 0; i < int'(W); i++) begin
            cnt = cnt + PW'(vec[i]);
         end
      end
   end else begin : g_chunk
      localparam int unsigned NCH  = (W + 3) / 4;
      localparam int unsigned PADW = NCH * 4;
      logic [PADW-1:0] padv;
      logic [2:0]      part [NCH];

      assign padv = PADW'(vec);
      for (genvar g = 0; g < int'(NCH); g++) begin : g_part
         assign part[g] = 3'(padv[4*g]) + 3'(padv[4*g+1])
                        + 3'(padv[4*g+2]) + 3'(padv[4*g+3]);
      end
      always_comb begin
         cnt = '0;
         for (int k = 0; k < int'(NCH); k++) begin
            cnt = cnt + PW'(part[k]);
         end
      end
   end
endmodule

// File: rtl/fi_sat_counter.sv
module fi_sat_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 1) begin : g_bad_w
      $error("fi_sat_counter: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc && (cnt != CNT_MAX)) begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R8
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(cnt)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R9
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0); // R10
endmodule

// File: rtl/fi_flip_mux.sv
module fi_flip_mux #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] mask_i,
   input  logic         apply_i,
   output logic [W-1:0] data_o
);
   for (genvar b = 0; b < int'(W); b++) begin : g_bit
      assign data_o[b] = data_i[b] ^ (mask_i[b] & apply_i);
   end
endmodule

// File: rtl/fi_stage_injector.sv
module fi_stage_injector
   import fi_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned N_HOT     = 1,
   parameter int unsigned CNT_W     = 32,
   parameter pop_style_e  POP_STYLE = POP_CHUNK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] fault_vec_i,
   input  logic              inject_i,
   input  logic              taint_i,
   input  logic              cnt_clr_i,
   output logic [DATA_W-1:0] data_o,
   output logic              taint_o,
   output logic              constraint_err_o,
   output logic [CNT_W-1:0]  inject_cnt_o
);
   localparam int unsigned PW = $clog2(DATA_W + 1);
   localparam logic [PW-1:0] HOT_TARGET = PW'(N_HOT);

   if (DATA_W < 1) begin : g_bad_data
      $error("fi_stage_injector: DATA_W must be at least 1");
   end
   if (N_HOT < 1 || N_HOT > DATA_W) begin : g_bad_hot
      $error("fi_stage_injector: N_HOT must lie in 1..DATA_W");
   end

   logic [PW-1:0] ones;
   logic          mask_ok;
   logic          apply;

   fi_popcount #(.W(DATA_W), .STYLE(POP_STYLE), .PW(PW)) u_pop (
      .vec (fault_vec_i),
      .cnt (ones)
   );

   assign mask_ok          = (ones == HOT_TARGET) && !taint_i;
   assign apply            = inject_i && mask_ok;
   assign constraint_err_o = inject_i && !mask_ok;
   assign taint_o          = taint_i || apply;

   fi_flip_mux #(.W(DATA_W)) u_flip (
      .data_i  (data_i),
      .mask_i  (fault_vec_i),
      .apply_i (apply),
      .data_o  (data_o)
   );

   fi_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr_i),
      .inc   (apply),
      .cnt   (inject_cnt_o)
   );

   AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !inject_i |-> data_o == data_i); // R1
   AST_FLIP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (inject_i && !constraint_err_o) |-> $countones(data_o ^ data_i) == N_HOT); // R2
   AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      constraint_err_o |-> data_o == data_i); // R4
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !inject_i |-> !constraint_err_o); // R5
   AST_TAINT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      taint_i |-> taint_o); // R6
   AST_TAINT_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (inject_i && taint_i) |-> (constraint_err_o && data_o == data_i)); // R7
endmodule

// File: tb/fi_stage_injector_test.sv
module fi_stage_injector_test;
   localparam int CLK_P = 10;
   localparam int DW    = 16;
   localparam int DW2   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;

   logic [DW-1:0] d_a, f_a, q_a;
   logic inj_a = 1'b0, tin_a = 1'b0, clr_a = 1'b0;
   logic tout_a, err_a;
   logic [31:0] cnt_a;

   logic [DW2-1:0] d_b, f_b, q_b;
   logic inj_b = 1'b0, tin_b = 1'b0, clr_b = 1'b0;
   logic tout_b, err_b;
   logic [2:0] cnt_b;

   int exp_cnt_a = 0;

   fi_stage_injector #(.DATA_W(DW), .N_HOT(1), .CNT_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .data_i(d_a), .fault_vec_i(f_a),
      .inject_i(inj_a), .taint_i(tin_a), .cnt_clr_i(clr_a),
      .data_o(q_a), .taint_o(tout_a), .constraint_err_o(err_a),
      .inject_cnt_o(cnt_a));

   fi_stage_injector #(.DATA_W(DW2), .N_HOT(2), .CNT_W(3),
                       .POP_STYLE(fi_pkg::POP_LOOP)) uut_sat (
      .clk(clk), .rst_n(rst_n), .data_i(d_b), .fault_vec_i(f_b),
      .inject_i(inj_b), .taint_i(tin_b), .cnt_clr_i(clr_b),
      .data_o(q_b), .taint_o(tout_b), .constraint_err_o(err_b),
      .inject_cnt_o(cnt_b));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive at falling edge, settle, then sample
   task automatic step();
      @(negedge clk);
   endtask

   task automatic t_reset();
      d_a = 16'h1234; f_a = 16'h0001; d_b = 8'h00; f_b = 8'h00;
      rst_n = 1'b0;
      repeat (2) step();
      rst_n = 1'b1;
      step(); #1;
      chk("R10 cnt after reset", cnt_a, 0);
      chk("R10 sat cnt after reset", 32'(cnt_b), 0);
      chk("R5 err idle after reset", 32'(err_a), 0);
   endtask

   task automatic t_pass();
      logic [DW-1:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h8001};
      for (int i = 0; i < 4; i++) begin
         d_a = pats[i]; f_a = ~pats[i]; inj_a = 1'b0; tin_a = 1'b0; #1;
         chk("R1 passthrough", 32'(q_a), 32'(pats[i]));
         chk("R5 no err when idle", 32'(err_a), 0);
         chk("R6 taint stays low idle", 32'(tout_a), 0);
      end
   endtask

   task automatic t_single();
      for (int b = 0; b < DW; b += 5) begin
         step();
         d_a = 16'h3C5A ^ 16'(b); f_a = 16'(1) << b; inj_a = 1'b1; #1;
         chk("R2 single flip", 32'(q_a), 32'((16'h3C5A ^ 16'(b)) ^ (16'(1) << b)));
         chk("R6 taint set on flip", 32'(tout_a), 1);
         chk("R5 no err legal", 32'(err_a), 0);
         exp_cnt_a++;
         step();
         inj_a = 1'b0; #1;
         chk("R3 one cycle only", 32'(q_a), 32'(d_a));
         chk("R8 count advanced", cnt_a, 32'(exp_cnt_a));
      end
   endtask

   task automatic t_bad_pop();
      logic [DW-1:0] bads [3] = '{16'h0000, 16'h0003, 16'hF00F};
      for (int i = 0; i < 3; i++) begin
         step();
         d_a = 16'h0F0F; f_a = bads[i]; inj_a = 1'b1; #1;
         chk("R4 err on bad popcount", 32'(err_a), 1);
         chk("R4 data unchanged", 32'(q_a), 32'h0F0F);
         step();
         inj_a = 1'b0; #1;
         chk("R4 count held", cnt_a, 32'(exp_cnt_a));
      end
   endtask

   task automatic t_taint();
      step();
      d_a = 16'h7777; f_a = 16'h0010; tin_a = 1'b1; inj_a = 1'b0; #1;
      chk("R6 taint forwarded", 32'(tout_a), 1);
      inj_a = 1'b1; #1;
      chk("R7 err on tainted item", 32'(err_a), 1);
      chk("R7 tainted data unchanged", 32'(q_a), 32'h7777);
      step();
      inj_a = 1'b0; tin_a = 1'b0; #1;
      chk("R7 count held", cnt_a, 32'(exp_cnt_a));
   endtask

   task automatic t_clear();
      step();
      clr_a = 1'b1; f_a = 16'h0100; inj_a = 1'b1;
      step();
      clr_a = 1'b0; inj_a = 1'b0; #1;
      exp_cnt_a = 0;
      chk("R10 clear beats increment", cnt_a, 0);
      inj_a = 1'b1;
      step();
      inj_a = 1'b0; #1;
      exp_cnt_a = 1;
      chk("R8 count after clear", cnt_a, 32'(exp_cnt_a));
   endtask

   task automatic t_sat();
      step();
      d_b = 8'hF0; f_b = 8'h01; inj_b = 1'b1; #1;
      chk("R4 one-hot refused at N_HOT=2", 32'(err_b), 1);
      chk("R4 data unchanged N_HOT=2", 32'(q_b), 32'hF0);
      f_b = 8'h81; #1;
      chk("R2 two-hot flip", 32'(q_b), 32'h71);
      for (int k = 0; k < 9; k++) step();
      inj_b = 1'b0; #1;
      chk("R9 saturated", 32'(cnt_b), 7);
      clr_b = 1'b1;
      step();
      clr_b = 1'b0; #1;
      chk("R10 sat clear", 32'(cnt_b), 0);
   endtask

   initial begin : watchdog
      #(CLK_P * 20000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      t_reset();
      t_pass();
      t_single();
      t_bad_pop();
      t_taint();
      t_clear();
      t_sat();
      step();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule